// File: doc/BRIEF.md
# Multi-Channel DMA Register Front End

This block is the register-side front end of a sixteen-channel DMA controller. It takes 32-bit accesses from a simple valid/ready register bus. Each access is steered to one channel's 256-byte register window or to one of two global registers. The global registers are a per-channel interrupt status word and a per-channel enable word. Channels 0 to 14 share one address window. The last channel is reached through a separate window with the same layout, selected by a window-select input.

Each channel has a control/status word with mixed write behaviour:
- a self-clearing reset bit;
- write-one-to-clear completion and interrupt flags;
- a set of bits that take the written value directly;
- an abort bit that does nothing.

Setting the active bit from 0 to 1 sends a one-cycle start pulse to the channel engine. The engines report completion and interrupts back into the status word. The engines expose their current descriptor through a small view port, which the front end reads on behalf of software.

Top module: `dmafe_regfront`

## Requirements
- R1: After reset every channel's control/status word and descriptor-address register read 0, the enable register reads 0x0000FFFF, the interrupt status word and `irq_out` are 0, and no start pulse or response is pending.
- R2: `req_ready` is always 1. Every accepted read gives exactly one `rsp_valid` pulse on the following cycle, carrying the data. Writes give no response.
- R3: In the main window, addresses below 0xF00 select channel `addr[11:8]` (0 to 14), with the register chosen by `addr[7:0]`. With `req_alt_win` set, the access goes to channel 15 using `addr[7:0]`, and `addr[11:8]` is ignored.
- R4: Per-channel offset 0x04 is the read/write descriptor address, driven on `chan_cb_addr`. Offset 0x20 is a read/write debug word. Offsets 0x08 to 0x1C are read-only. They return `view_data` while `view_chan` names the channel and `view_sel` = (offset−8)/4. Writes to them change nothing.
- R5: A write to offset 0x00 (control/status) replaces the bits in mask 0x30FF0001 with the written value. All other bits keep their value.
- R6: Writing bit 31 of the control/status word clears that word and the channel's descriptor address before the masked update is applied. Bit 31 always reads back 0.
- R7: Writing 1 to bit 1 clears the completion flag. Writing 1 to bit 2 clears the interrupt flag, the channel's bit in the status word and its `irq_out` line.
- R8: `chan_start[c]` pulses for one cycle, on the cycle after a control/status write, only when that write moves bit 0 (active) of channel c from 0 to 1.
- R9: Writing bit 30 (abort) has no effect of its own.
- R10: Offset 0xFE0 of the main window reads the status word, whose bit c is channel c's interrupt flag; writes to it are ignored. Offset 0xFF0 holds the 16 enable bits, written from `wdata[15:0]` and driven on `chan_enable`.
- R11: Reads of any other offset, including unaligned ones, return 0. Writes to them change nothing.
- R12: A pulse on `eng_irq[c]` sets channel c's interrupt flag (bit 2), its status bit and `irq_out[c]` at the same clock edge. It wins over a software clear in that cycle.
- R13: A pulse on `eng_end[c]` sets bit 1 (completion) and clears bit 0 (active). A control/status write to that channel in the same cycle decides bit 0 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alt_win | input | 1 | Selects the separate last-channel window |
| req_addr | input | 12 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| view_chan | output | 4 | Channel whose descriptor view is requested |
| view_sel | output | 3 | Descriptor word index 0..5 |
| view_data | input | 32 | Descriptor word returned by the engines |
| eng_irq | input | 16 | Per-channel interrupt assertion pulses |
| eng_end | input | 16 | Per-channel completion pulses |
| chan_start | output | 16 | Per-channel start pulses |
| chan_enable | output | 16 | Per-channel enable bits |
| chan_cb_addr | output | 512 | Descriptor address of each channel, channel c at bits 32c+31:32c |
| irq_out | output | 16 | Per-channel interrupt lines |

## Verification
Two pairs of functions can fall in the same cycle:
- an engine interrupt and a software write-one-to-clear of that interrupt;
- an engine completion and a software control/status write to the same channel.

The bench provokes each pair by raising the engine pulse in the exact cycle the write is presented. It then judges the outcome from `irq_out`, the status word and a read-back of the control/status word. The interrupt must survive the clear. The written active bit must survive the completion, while the completion flag is still set.

// File: rtl/dmafe_pkg.sv
// Package: shared constants and types for the DMA register front end.
// Assumes 32-bit data and 12-bit window offsets.
package dmafe_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // Per-channel register offsets (within a 256-byte window)
    localparam logic [7:0] OFF_CS      = 8'h00;
    localparam logic [7:0] OFF_CB      = 8'h04;
    localparam logic [7:0] OFF_VIEW_LO = 8'h08;
    localparam logic [7:0] OFF_VIEW_HI = 8'h1C;
    localparam logic [7:0] OFF_DBG     = 8'h20;

    // Global region of the main window
    localparam logic [ADDR_W-1:0] GLB_BASE   = 12'hF00;
    localparam logic [ADDR_W-1:0] GLB_STATUS = 12'hFE0;
    localparam logic [ADDR_W-1:0] GLB_ENABLE = 12'hFF0;

    // Control/status bit positions
    localparam int CS_ACTIVE = 0;
    localparam int CS_END    = 1;
    localparam int CS_INT    = 2;
    localparam int CS_ABORT  = 30;
    localparam int CS_RESET  = 31;
    localparam logic [DATA_W-1:0] CS_WMASK = 32'h30FF_0001;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CS,
        RK_CB,
        RK_VIEW,
        RK_DBG,
        RK_STATUS,
        RK_ENABLE
    } reg_kind_e;
endpackage

// File: rtl/dmafe_decode.sv
// Module: address decoder. Turns window select plus offset into a register
// kind, a channel index and a descriptor view index. Purely combinational.
// Assumes NUM_CH <= 16 and that the last channel lives only in the alt window.
module dmafe_decode
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              alt_win,
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   chan,
    output logic [2:0]        view_sel
);
    localparam int LAST_CH = NUM_CH - 1;

    logic [7:0] off;
    logic       main_chan_hit;
    reg_kind_e  chan_kind;

    // Offset within the channel window and main-window channel range check
    always_comb begin
        off           = addr[7:0];
        main_chan_hit = (addr < GLB_BASE) && (int'(addr[11:8]) < LAST_CH);
    end

    // Register kind inside one channel window
    always_comb begin
        chan_kind = RK_NONE;
        if (off[1:0] == 2'b00) begin
            if (off == OFF_CS)
                chan_kind = RK_CS;
            else if (off == OFF_CB)
                chan_kind = RK_CB;
            else if (off == OFF_DBG)
                chan_kind = RK_DBG;
            else if (off >= OFF_VIEW_LO && off <= OFF_VIEW_HI)
                chan_kind = RK_VIEW;
        end
    end

    // Final kind and channel selection across both windows
    always_comb begin
        kind     = RK_NONE;
        chan     = CH_W'(addr[11:8]);
        view_sel = off[4:2] - 3'd2;
        if (alt_win) begin
            chan = CH_W'(LAST_CH);
            kind = chan_kind;
        end else if (main_chan_hit) begin
            kind = chan_kind;
        end else if (addr == GLB_STATUS) begin
            kind = RK_STATUS;
        end else if (addr == GLB_ENABLE) begin
            kind = RK_ENABLE;
        end
    end
endmodule

// File: rtl/dmafe_chan_regs.sv
// Module: one channel's register set: control/status word, descriptor
// address and debug word. Applies the control/status write rules, engine
// completion/interrupt events and generates the start pulse.
// Assumes at most one software write strobe is active per cycle.
module dmafe_chan_regs
    import dmafe_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cs,
    input  logic          wr_cb,
    input  logic          wr_dbg,
    input  logic [DW-1:0] wdata,
    input  logic          eng_irq,
    input  logic          eng_end,
    output logic [DW-1:0] cs_q,
    output logic [DW-1:0] cb_q,
    output logic [DW-1:0] dbg_q,
    output logic          start_q
);
    logic [DW-1:0] cs_base;
    logic [DW-1:0] cs_d;
    logic [DW-1:0] cb_d;
    logic          start_d;

    // Next control/status value: software rules first, engine events on top
    always_comb begin
        cs_base = wdata[CS_RESET] ? '0 : cs_q;
        if (wdata[CS_END])
            cs_base[CS_END] = 1'b0;
        if (wdata[CS_INT])
            cs_base[CS_INT] = 1'b0;
        if (wr_cs)
            cs_d = (cs_base & ~CS_WMASK) | (wdata & CS_WMASK);
        else if (eng_end)
            cs_d = cs_q & ~(DW'(1) << CS_ACTIVE);
        else
            cs_d = cs_q;
        if (eng_end)
            cs_d[CS_END] = 1'b1;
        if (eng_irq)
            cs_d[CS_INT] = 1'b1;
    end

    // Start request on a software-caused rise of the active bit
    always_comb begin
        start_d = wr_cs && !cs_q[CS_ACTIVE] && wdata[CS_ACTIVE];
    end

    // Descriptor address: channel reset clears it, plain write loads it
    always_comb begin
        if (wr_cs && wdata[CS_RESET])
            cb_d = '0;
        else if (wr_cb)
            cb_d = wdata;
        else
            cb_d = cb_q;
    end

    // State registers of the channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= '0;
            cb_q    <= '0;
            dbg_q   <= '0;
            start_q <= 1'b0;
        end else begin
            cs_q    <= cs_d;
            cb_q    <= cb_d;
            start_q <= start_d;
            if (wr_dbg)
                dbg_q <= wdata;
        end
    end
endmodule

// File: rtl/dmafe_rdmux.sv
// Module: read data selection across channel registers, the engine view
// port and the global registers. Combinational; the top registers it.
// Assumes NUM_CH is a power of two so every channel index is in range.
module dmafe_rdmux
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int DW     = DATA_W
) (
    input  reg_kind_e       kind,
    input  logic [CH_W-1:0] chan,
    input  logic [DW-1:0]   cs_arr  [NUM_CH],
    input  logic [DW-1:0]   cb_arr  [NUM_CH],
    input  logic [DW-1:0]   dbg_arr [NUM_CH],
    input  logic [DW-1:0]   view_data,
    input  logic [NUM_CH-1:0] status,
    input  logic [NUM_CH-1:0] enable,
    output logic [DW-1:0]   rdata
);
    // Select the read word by register kind
    always_comb begin
        case (kind)
            RK_CS:     rdata = cs_arr[chan];
            RK_CB:     rdata = cb_arr[chan];
            RK_DBG:    rdata = dbg_arr[chan];
            RK_VIEW:   rdata = view_data;
            RK_STATUS: rdata = DW'(status);
            RK_ENABLE: rdata = DW'(enable);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmafe_regfront.sv
// Module: top of the DMA register front end. Decodes bus accesses, holds
// per-channel registers and the global enable word, gathers interrupt
// flags into the status word and returns read data one cycle later.
// Assumes one access per cycle and fixed 32-bit accesses.
module dmafe_regfront
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_alt_win,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    output logic [CH_W-1:0]      view_chan,
    output logic [2:0]           view_sel,
    input  logic [DW-1:0]        view_data,
    input  logic [NUM_CH-1:0]    eng_irq,
    input  logic [NUM_CH-1:0]    eng_end,
    output logic [NUM_CH-1:0]    chan_start,
    output logic [NUM_CH-1:0]    chan_enable,
    output logic [NUM_CH*DW-1:0] chan_cb_addr,
    output logic [NUM_CH-1:0]    irq_out
);
    reg_kind_e         kind;
    logic [CH_W-1:0]   chan;
    logic              do_wr;
    logic              do_rd;
    logic [DW-1:0]     cs_arr  [NUM_CH];
    logic [DW-1:0]     cb_arr  [NUM_CH];
    logic [DW-1:0]     dbg_arr [NUM_CH];
    logic [NUM_CH-1:0] status;
    logic [NUM_CH-1:0] enable_q;
    logic [DW-1:0]     rd_word;

    // Bus handshake: every presented request is taken at once
    always_comb begin
        req_ready = 1'b1;
        do_wr     = req_valid && req_write;
        do_rd     = req_valid && !req_write;
    end

    dmafe_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_decode (
        .alt_win  (req_alt_win),
        .addr     (req_addr),
        .kind     (kind),
        .chan     (chan),
        .view_sel (view_sel)
    );

    // Engine view port follows the decoded channel
    always_comb begin
        view_chan = chan;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic sel;

        // Channel hit for this instance
        always_comb begin
            sel = do_wr && (chan == CH_W'(c));
        end

        dmafe_chan_regs #(
            .DW (DW)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cs   (sel && (kind == RK_CS)),
            .wr_cb   (sel && (kind == RK_CB)),
            .wr_dbg  (sel && (kind == RK_DBG)),
            .wdata   (req_wdata),
            .eng_irq (eng_irq[c]),
            .eng_end (eng_end[c]),
            .cs_q    (cs_arr[c]),
            .cb_q    (cb_arr[c]),
            .dbg_q   (dbg_arr[c]),
            .start_q (chan_start[c])
        );

        // Per-channel outputs gathered from the channel registers
        always_comb begin
            status[c]                 = cs_arr[c][CS_INT];
            chan_cb_addr[c*DW +: DW]  = cb_arr[c];
        end
    end

    // Interrupt lines mirror the status word
    always_comb begin
        irq_out     = status;
        chan_enable = enable_q;
    end

    dmafe_rdmux #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .DW     (DW)
    ) u_rdmux (
        .kind      (kind),
        .chan      (chan),
        .cs_arr    (cs_arr),
        .cb_arr    (cb_arr),
        .dbg_arr   (dbg_arr),
        .view_data (view_data),
        .status    (status),
        .enable    (enable_q),
        .rdata     (rd_word)
    );

    // Global enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '1;
        else if (do_wr && kind == RK_ENABLE)
            enable_q <= req_wdata[NUM_CH-1:0];
    end

    // Registered read response, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= do_rd;
            if (do_rd)
                rsp_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/dmafe_regfront_chk.sv
// Module: protocol and behaviour checker for dmafe_regfront, bound to it.
// Observes ports only.
module dmafe_regfront_chk
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int AW     = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              req_alt_win,
    input logic [AW-1:0]     req_addr,
    input logic              rsp_valid,
    input logic [NUM_CH-1:0] eng_irq,
    input logic [NUM_CH-1:0] chan_start,
    input logic [NUM_CH-1:0] chan_enable,
    input logic [NUM_CH-1:0] irq_out
);
    p_always_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready);

    p_read_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_start_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_start));

    p_start_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> (chan_start == '0));

    p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && !req_alt_win && req_addr == GLB_ENABLE)
        |=> $stable(chan_enable));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
            chan_start[c] |=> !chan_start[c]);

        p_irq_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            eng_irq[c] |=> irq_out[c]);
    end
endmodule

bind dmafe_regfront dmafe_regfront_chk #(
    .NUM_CH (NUM_CH),
    .AW     (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_alt_win (req_alt_win),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .eng_irq     (eng_irq),
    .chan_start  (chan_start),
    .chan_enable (chan_enable),
    .irq_out     (irq_out)
);

// File: tb/dmafe_regfront_tb_top.sv
// Directed bench for dmafe_regfront: one task per scenario.
module dmafe_regfront_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_write = 1'b0;
    logic                 req_alt_win = 1'b0;
    logic [11:0]          req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic [3:0]           view_chan;
    logic [2:0]           view_sel;
    logic [31:0]          view_data;
    logic [NUM_CH-1:0]    eng_irq = '0;
    logic [NUM_CH-1:0]    eng_end = '0;
    logic [NUM_CH-1:0]    chan_start;
    logic [NUM_CH-1:0]    chan_enable;
    logic [NUM_CH*32-1:0] chan_cb_addr;
    logic [NUM_CH-1:0]    irq_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Engine view model: tag, channel and word index
    assign view_data = {8'hA5, 12'h000, view_chan, 5'h00, view_sel};

    dmafe_regfront dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_alt_win  (req_alt_win),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .view_chan    (view_chan),
        .view_sel     (view_sel),
        .view_data    (view_data),
        .eng_irq      (eng_irq),
        .eng_end      (eng_end),
        .chan_start   (chan_start),
        .chan_enable  (chan_enable),
        .chan_cb_addr (chan_cb_addr),
        .irq_out      (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic bus_wr(input logic alt, input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_alt_win = alt;
        req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_alt_win = 1'b0;
    endtask

    task automatic bus_rd(input logic alt, input logic [11:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_alt_win = alt; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_alt_win = 1'b0;
        chk("R2 rsp_valid after read", 32'(rsp_valid), 32'd1);
        d = rsp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic alt, input logic [11:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(alt, a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_end(input int c);
        eng_end[c] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eng_end = '0;
    endtask

    task automatic pulse_irq(input int c);
        eng_irq[c] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eng_irq = '0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        chk("R1 irq_out", 32'(irq_out), 32'd0);
        chk("R1 chan_start", 32'(chan_start), 32'd0);
        chk("R1 chan_enable", 32'(chan_enable), 32'h0000FFFF);
        chk("R2 req_ready", 32'(req_ready), 32'd1);
        rd_chk("R1 cs ch0", 1'b0, 12'h000, 32'h0);
        rd_chk("R1 cb ch9", 1'b0, 12'h904, 32'h0);
        rd_chk("R1 enable", 1'b0, 12'hFF0, 32'h0000FFFF);
        rd_chk("R1 status", 1'b0, 12'hFE0, 32'h0);
    endtask

    task automatic t_decode();
        bus_wr(1'b0, 12'h304, 32'h1111_0303);
        rd_chk("R3 cb ch3", 1'b0, 12'h304, 32'h1111_0303);
        rd_chk("R3 cb ch4 untouched", 1'b0, 12'h404, 32'h0);
        chk("R4 chan_cb_addr ch3", chan_cb_addr[3*32 +: 32], 32'h1111_0303);
        bus_wr(1'b1, 12'h004, 32'hCAFE_0015);
        rd_chk("R3 alt window ignores 11:8", 1'b1, 12'h504, 32'hCAFE_0015);
        chk("R3 alt window reaches ch15", chan_cb_addr[15*32 +: 32], 32'hCAFE_0015);
        rd_chk("R3 ch0 not hit by alt", 1'b0, 12'h004, 32'h0);
        bus_wr(1'b0, 12'h720, 32'hDEB0_0007);
        rd_chk("R4 debug ch7", 1'b0, 12'h720, 32'hDEB0_0007);
    endtask

    task automatic t_view();
        rd_chk("R4 view ch2 word2", 1'b0, 12'h210, 32'hA500_0202);
        rd_chk("R4 view ch11 word0", 1'b0, 12'hB08, 32'hA500_0B00);
        rd_chk("R4 view ch15 word5", 1'b1, 12'h01C, 32'hA500_0F05);
        bus_wr(1'b0, 12'h210, 32'hFFFF_FFFF);
        rd_chk("R4 view write dropped cs", 1'b0, 12'h200, 32'h0);
        rd_chk("R4 view write dropped cb", 1'b0, 12'h204, 32'h0);
        rd_chk("R4 view write dropped dbg", 1'b0, 12'h220, 32'h0);
    endtask

    task automatic t_cs_mask();
        bus_wr(1'b0, 12'h100, 32'h7FFF_FFF8);
        chk("R5 no start without active", 32'(chan_start), 32'd0);
        rd_chk("R5 masked write", 1'b0, 12'h100, 32'h30FF_0000);
        bus_wr(1'b0, 12'h100, 32'h70FF_0000);
        rd_chk("R9 abort no effect", 1'b0, 12'h100, 32'h30FF_0000);
        bus_wr(1'b0, 12'h100, 32'h1000_0000);
        rd_chk("R5 masked bits replaced", 1'b0, 12'h100, 32'h1000_0000);
        bus_wr(1'b0, 12'h100, 32'h8000_0000);
        rd_chk("R6 reset clears cs", 1'b0, 12'h100, 32'h0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        bus_wr(1'b0, 12'h504, 32'h0000_1234);
        bus_wr(1'b0, 12'h500, 32'h0000_0001);
        chk("R8 start pulse on rise", 32'(chan_start), 32'h0000_0020);
        bus_rd(1'b0, 12'h500, v);
        chk("R8 start is one cycle", 32'(chan_start), 32'd0);
        chk("R5 active set", v, 32'h1);
        bus_wr(1'b0, 12'h500, 32'h0000_0001);
        chk("R8 no start when already active", 32'(chan_start), 32'd0);
        bus_wr(1'b0, 12'h500, 32'h8000_0001);
        chk("R8 no start after reset+active", 32'(chan_start), 32'd0);
        rd_chk("R6 reset then masked", 1'b0, 12'h500, 32'h1);
        rd_chk("R6 reset clears cb", 1'b0, 12'h504, 32'h0);
        pulse_end(5);
        rd_chk("R13 end sets flag clears active", 1'b0, 12'h500, 32'h2);
        bus_wr(1'b0, 12'h500, 32'h0000_0001);
        chk("R8 restart pulse", 32'(chan_start), 32'h0000_0020);
        rd_chk("R7 end kept without clear", 1'b0, 12'h500, 32'h3);
        bus_wr(1'b0, 12'h500, 32'h0000_0002);
        rd_chk("R7 end cleared by w1c", 1'b0, 12'h500, 32'h0);
    endtask

    task automatic t_irq();
        pulse_irq(6);
        chk("R12 irq line set", 32'(irq_out), 32'h40);
        rd_chk("R12 status bit set", 1'b0, 12'hFE0, 32'h40);
        rd_chk("R12 int flag in cs", 1'b0, 12'h600, 32'h4);
        bus_wr(1'b0, 12'hFE0, 32'hFFFF_FFFF);
        rd_chk("R10 status write ignored", 1'b0, 12'hFE0, 32'h40);
        bus_wr(1'b0, 12'h600, 32'h0000_0004);
        chk("R7 irq line cleared", 32'(irq_out), 32'h0);
        rd_chk("R7 status cleared", 1'b0, 12'hFE0, 32'h0);
        pulse_irq(6);
        eng_irq[6] = 1'b1;
        bus_wr(1'b0, 12'h600, 32'h0000_0004);
        eng_irq = '0;
        chk("R12 assertion beats clear", 32'(irq_out), 32'h40);
        rd_chk("R12 int flag kept", 1'b0, 12'h600, 32'h4);
        bus_wr(1'b0, 12'h600, 32'h0000_0004);
        chk("R7 final clear", 32'(irq_out), 32'h0);
    endtask

    task automatic t_enable();
        bus_wr(1'b0, 12'hFF0, 32'h1234_00F0);
        chk("R10 chan_enable written", 32'(chan_enable), 32'h0000_00F0);
        rd_chk("R10 enable readback", 1'b0, 12'hFF0, 32'h0000_00F0);
        bus_wr(1'b1, 12'hFF0, 32'h0000_0000);
        chk("R11 alt FF0 not enable", 32'(chan_enable), 32'h0000_00F0);
        bus_wr(1'b0, 12'hFF0, 32'h0000_FFFF);
        chk("R10 enable restored", 32'(chan_enable), 32'h0000_FFFF);
    endtask

    task automatic t_unmapped();
        rd_chk("R11 ch0 offset 0x24", 1'b0, 12'h024, 32'h0);
        rd_chk("R11 unaligned", 1'b0, 12'h722, 32'h0);
        rd_chk("R11 global gap", 1'b0, 12'hF04, 32'h0);
        rd_chk("R11 alt offset E0", 1'b1, 12'h0E0, 32'h0);
        bus_wr(1'b0, 12'hF04, 32'hDEAD_BEEF);
        bus_wr(1'b0, 12'h030, 32'hDEAD_BEEF);
        rd_chk("R11 enable untouched", 1'b0, 12'hFF0, 32'h0000_FFFF);
        rd_chk("R11 status untouched", 1'b0, 12'hFE0, 32'h0);
        rd_chk("R11 ch0 cs untouched", 1'b0, 12'h000, 32'h0);
        rd_chk("R11 ch0 cb untouched", 1'b0, 12'h004, 32'h0);
        rd_chk("R11 ch0 dbg untouched", 1'b0, 12'h020, 32'h0);
    endtask

    task automatic t_end_race();
        bus_wr(1'b0, 12'h800, 32'h0000_0001);
        chk("R8 start ch8", 32'(chan_start), 32'h0000_0100);
        eng_end[8] = 1'b1;
        bus_wr(1'b0, 12'h800, 32'h0001_0001);
        eng_end = '0;
        chk("R8 no start in race", 32'(chan_start), 32'd0);
        rd_chk("R13 write keeps active, end set", 1'b0, 12'h800, 32'h0001_0003);
        pulse_end(8);
        rd_chk("R13 end alone clears active", 1'b0, 12'h800, 32'h0001_0002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_view();
        t_cs_mask();
        t_start();
        t_irq();
        t_enable();
        t_unmapped();
        t_end_race();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule